// File: doc/BRIEF.md
# Port Pin Function Override Mux

This block owns an eight-pin general-purpose port whose pins can be taken over by system functions. Software-facing data and direction registers are loaded through plain write strobes. For every pad the block produces a drive value, a drive enable and a read-back bit. Interrupt logic and clock-output logic each supply enable inputs. When the function tied to a pin is active, that function sets the pin's direction and, for output functions, its drive value. The registered GPIO setting is ignored for as long as the function stays active.

Every override has fixed priority over the GPIO registers. Pins 7, 6 and 3 carry no alternate function. Pin 5 serves the non-maskable interrupt. Once the interrupt mask bit is cleared, pin 5 turns into an input and stays an input until the next reset, even if the mask is set again. Pin 4 is an input while the maskable interrupt is enabled. Pins 2, 1 and 0 become outputs carrying the double-rate bus clock, the periodic-interrupt clock and the bus clock respectively.

A debug pad is kept undriven while reset is held. Its level during reset is latched into a read-only mode bit, which keeps its value until the next reset.

Top module: `pin_takeover_port`

## Requirements
- R1: While `rstN` is low at a clock edge, both registers clear to 0. With no override active, the block then shows `padOe`=0x00 and `padOut`=0x00, and `rdPort` equals `padIn`.
- R2: On a pin with no active override, `padOe[i]` equals direction bit i and `padOut[i]` equals data bit i.
- R3: `rdPort[i]` equals data bit i when `padOe[i]` is 1, and `padIn[i]` when `padOe[i]` is 0.
- R4: Pin 5 is forced to input (`padOe[5]`=0) from the first clock edge after reset at which `xMaskBit` is sampled 0. It stays forced even after `xMaskBit` returns to 1, and only reset clears it.
- R5: While `irqEnable` is 1, `padOe[4]`=0, whatever the direction register holds.
- R6: While `eclk2xEn` is 1, `padOe[2]`=1 and `padOut[2]` follows `eclk2x`.
- R7: While both `apiClkEn` and `apiClkRoute` are 1, `padOe[1]`=1 and `padOut[1]` follows `apiClk`. Either enable alone has no effect on pin 1.
- R8: While `eclkEn` is 1, `padOe[0]`=1 and `padOut[0]` follows `eclk`.
- R9: Pins 7, 6 and 3 always behave as in R2, whatever the override inputs do.
- R10: `modeBit` holds the level that `dbgPin` had at the last clock edge with `rstN` low. It does not change while `rstN` stays high.
- R11: `dbgPadOe` is 0 while `rstN` is low and equals `dbgOeReq` otherwise.
- R12: A clock edge with `wrDataStb`=1 loads `wrData` into the data register. An edge with `wrDirStb`=1 loads `wrData` into the direction register. Both may load in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| wrData | input | 8 | Write data for the port registers |
| wrDataStb | input | 1 | Load data register |
| wrDirStb | input | 1 | Load direction register (1 = output) |
| xMaskBit | input | 1 | Non-maskable interrupt mask bit from the CPU |
| irqEnable | input | 1 | Maskable interrupt pin enable |
| eclk2xEn | input | 1 | Double-rate bus clock output enable |
| eclk2x | input | 1 | Double-rate bus clock |
| apiClkEn | input | 1 | Periodic-interrupt clock enable |
| apiClkRoute | input | 1 | Route periodic-interrupt clock to pin 1 |
| apiClk | input | 1 | Periodic-interrupt clock |
| eclkEn | input | 1 | Bus clock output enable |
| eclk | input | 1 | Bus clock |
| padIn | input | 8 | Pad input levels |
| dbgPin | input | 1 | Debug pad input level |
| dbgOeReq | input | 1 | Drive request from debug logic |
| padOut | output | 8 | Pad drive values |
| padOe | output | 8 | Pad drive enables |
| rdPort | output | 8 | Port read-back value |
| modeBit | output | 1 | Mode bit latched during reset |
| dbgPadOe | output | 1 | Debug pad drive enable |

## Verification
The bench sweeps all 256 direction patterns against every combination of the override inputs. For each combination it checks each pad, so a swapped pin, a wrong priority, or a routing condition that checks only one of its two enables will each show up as a wrong drive enable. It then clears the mask bit and sets it again. A latch that is not sticky would drive pin 5 once more, and one that reset fails to clear would leave pin 5 an input after the next reset. The bench also changes the debug pad after reset is released. A mode bit that keeps sampling the pad would follow that change and not keep the level it had during reset. Finally, the read-back is checked on both output and input pins. A mux that always returns the pad level, or always the register, would return the wrong value on one of the two.

// File: rtl/ptp_pkg.sv
package ptp_pkg;

  localparam int PORT_W = 8;

  // pin positions that carry an alternate function
  localparam int PIN_NMI    = 5;
  localparam int PIN_IRQ    = 4;
  localparam int PIN_CLK2X  = 2;
  localparam int PIN_APICLK = 1;
  localparam int PIN_BUSCLK = 0;

  typedef enum logic [1:0] {
    ROLE_GPIO     = 2'd0,
    ROLE_FORCE_IN = 2'd1,
    ROLE_CLK_OUT  = 2'd2
  } pinRole_e;

  function automatic pinRole_e pinRole(input int idx);
    case (idx)
      PIN_NMI, PIN_IRQ:                  return ROLE_FORCE_IN;
      PIN_CLK2X, PIN_APICLK, PIN_BUSCLK: return ROLE_CLK_OUT;
      default:                           return ROLE_GPIO;
    endcase
  endfunction

  // strobes from control to datapath, one bit per pin
  typedef struct packed {
    logic [PORT_W-1:0] forceIn;
    logic [PORT_W-1:0] forceOut;
    logic [PORT_W-1:0] perVal;
  } ovrCtl_t;

endpackage

// File: rtl/ptp_ctrl.sv
module ptp_ctrl
  import ptp_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    xMaskBit,
  input  logic    irqEnable,
  input  logic    eclk2xEn,
  input  logic    eclk2x,
  input  logic    apiClkEn,
  input  logic    apiClkRoute,
  input  logic    apiClk,
  input  logic    eclkEn,
  input  logic    eclk,
  input  logic    dbgPin,
  input  logic    dbgOeReq,
  output ovrCtl_t ctl,
  output logic    modeBit,
  output logic    dbgPadOe
);

  logic              nmiLockQ;
  logic              modeQ;
  logic [PORT_W-1:0] inReq;
  logic [PORT_W-1:0] outReq;
  logic [PORT_W-1:0] outVal;

  // sticky input lock for the non-maskable interrupt pin
  always_ff @(posedge clk) begin
    if (!rstN) nmiLockQ <= 1'b0;
    else if (!xMaskBit) nmiLockQ <= 1'b1;
  end

  // mode bit follows the debug pad while reset is held, then freezes
  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= dbgPin;
  end

  assign modeBit  = modeQ;
  assign dbgPadOe = rstN & dbgOeReq;

  // collect per-pin requests from the system functions
  always_comb begin
    inReq  = '0;
    outReq = '0;
    outVal = '0;
    inReq[PIN_NMI]     = nmiLockQ;
    inReq[PIN_IRQ]     = irqEnable;
    outReq[PIN_CLK2X]  = eclk2xEn;
    outVal[PIN_CLK2X]  = eclk2x;
    outReq[PIN_APICLK] = apiClkEn & apiClkRoute;
    outVal[PIN_APICLK] = apiClk;
    outReq[PIN_BUSCLK] = eclkEn;
    outVal[PIN_BUSCLK] = eclk;
  end

  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    if (pinRole(i) == ROLE_FORCE_IN) begin : g_in
      assign ctl.forceIn[i]  = inReq[i];
      assign ctl.forceOut[i] = 1'b0;
      assign ctl.perVal[i]   = 1'b0;
    end else if (pinRole(i) == ROLE_CLK_OUT) begin : g_out
      assign ctl.forceIn[i]  = 1'b0;
      assign ctl.forceOut[i] = outReq[i];
      assign ctl.perVal[i]   = outVal[i];
    end else begin : g_gpio
      assign ctl.forceIn[i]  = 1'b0;
      assign ctl.forceOut[i] = 1'b0;
      assign ctl.perVal[i]   = 1'b0;
    end
  end

  // R4: a cleared mask bit locks pin 5 from the next edge on
  a_r4_lock_sets: assert property (@(posedge clk) disable iff (!rstN)
    !xMaskBit |=> ctl.forceIn[PIN_NMI]);

  // R4: once locked, the pin stays locked until reset
  a_r4_lock_keeps: assert property (@(posedge clk) disable iff (!rstN)
    ctl.forceIn[PIN_NMI] |=> ctl.forceIn[PIN_NMI]);

  // R10: mode bit frozen while out of reset
  a_r10_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> $stable(modeBit));

  // R11: debug pad never driven during reset
  always_comb begin
    if (!rstN) a_r11_dbg_quiet: assert (!dbgPadOe);
  end

  // unused-bit sinks (non-override pins)
  logic unusedBits;
  assign unusedBits = ^{inReq, outReq, outVal};

endmodule

// File: rtl/ptp_datapath.sv
module ptp_datapath
  import ptp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [PORT_W-1:0] wrData,
  input  logic              wrDataStb,
  input  logic              wrDirStb,
  input  ovrCtl_t           ctl,
  input  logic [PORT_W-1:0] padIn,
  output logic [PORT_W-1:0] padOut,
  output logic [PORT_W-1:0] padOe,
  output logic [PORT_W-1:0] rdPort
);

  logic [PORT_W-1:0] dataQ;
  logic [PORT_W-1:0] dirQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ <= '0;
      dirQ  <= '0;
    end else begin
      if (wrDataStb) dataQ <= wrData;
      if (wrDirStb)  dirQ  <= wrData;
    end
  end

  for (genvar i = 0; i < PORT_W; i++) begin : g_pad
    always_comb begin
      if (ctl.forceOut[i]) begin
        padOe[i]  = 1'b1;
        padOut[i] = ctl.perVal[i];
      end else if (ctl.forceIn[i]) begin
        padOe[i]  = 1'b0;
        padOut[i] = dataQ[i];
      end else begin
        padOe[i]  = dirQ[i];
        padOut[i] = dataQ[i];
      end
    end

    assign rdPort[i] = padOe[i] ? dataQ[i] : padIn[i];

    // R3: output pins read back the register, input pins the pad
    a_r3_read_src: assert property (@(posedge clk) disable iff (!rstN)
      padOe[i] ? (rdPort[i] == dataQ[i]) : (rdPort[i] == padIn[i]));

    // R6/R8: a forced output pin is always driven
    a_r6_forced_drive: assert property (@(posedge clk) disable iff (!rstN)
      ctl.forceOut[i] |-> padOe[i]);
  end

  // R12: strobes load the registers on the edge
  a_r12_data_load: assert property (@(posedge clk) disable iff (!rstN)
    wrDataStb |=> dataQ == $past(wrData));

  a_r12_dir_load: assert property (@(posedge clk) disable iff (!rstN)
    wrDirStb |=> dirQ == $past(wrData));

endmodule

// File: rtl/pin_takeover_port.sv
module pin_takeover_port
  import ptp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [PORT_W-1:0] wrData,
  input  logic              wrDataStb,
  input  logic              wrDirStb,
  input  logic              xMaskBit,
  input  logic              irqEnable,
  input  logic              eclk2xEn,
  input  logic              eclk2x,
  input  logic              apiClkEn,
  input  logic              apiClkRoute,
  input  logic              apiClk,
  input  logic              eclkEn,
  input  logic              eclk,
  input  logic [PORT_W-1:0] padIn,
  input  logic              dbgPin,
  input  logic              dbgOeReq,
  output logic [PORT_W-1:0] padOut,
  output logic [PORT_W-1:0] padOe,
  output logic [PORT_W-1:0] rdPort,
  output logic              modeBit,
  output logic              dbgPadOe
);

  ovrCtl_t ctl;

  ptp_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .xMaskBit   (xMaskBit),
    .irqEnable  (irqEnable),
    .eclk2xEn   (eclk2xEn),
    .eclk2x     (eclk2x),
    .apiClkEn   (apiClkEn),
    .apiClkRoute(apiClkRoute),
    .apiClk     (apiClk),
    .eclkEn     (eclkEn),
    .eclk       (eclk),
    .dbgPin     (dbgPin),
    .dbgOeReq   (dbgOeReq),
    .ctl        (ctl),
    .modeBit    (modeBit),
    .dbgPadOe   (dbgPadOe)
  );

  ptp_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wrData    (wrData),
    .wrDataStb (wrDataStb),
    .wrDirStb  (wrDirStb),
    .ctl       (ctl),
    .padIn     (padIn),
    .padOut    (padOut),
    .padOe     (padOe),
    .rdPort    (rdPort)
  );

endmodule

// File: tb/pin_takeover_port_tb.sv
module pin_takeover_port_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] wrData;
  logic       wrDataStb, wrDirStb;
  logic       xMaskBit, irqEnable;
  logic       eclk2xEn, eclk2x, apiClkEn, apiClkRoute, apiClk, eclkEn, eclk;
  logic [7:0] padIn;
  logic       dbgPin, dbgOeReq;
  logic [7:0] padOut, padOe, rdPort;
  logic       modeBit, dbgPadOe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // bench model state
  logic [7:0] dataM, dirM;
  bit         lockM;

  pin_takeover_port u_dut (
    .clk(clk), .rstN(rstN), .wrData(wrData), .wrDataStb(wrDataStb),
    .wrDirStb(wrDirStb), .xMaskBit(xMaskBit), .irqEnable(irqEnable),
    .eclk2xEn(eclk2xEn), .eclk2x(eclk2x), .apiClkEn(apiClkEn),
    .apiClkRoute(apiClkRoute), .apiClk(apiClk), .eclkEn(eclkEn), .eclk(eclk),
    .padIn(padIn), .dbgPin(dbgPin), .dbgOeReq(dbgOeReq), .padOut(padOut),
    .padOe(padOe), .rdPort(rdPort), .modeBit(modeBit), .dbgPadOe(dbgPadOe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles, expected at most %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] expOe();
    logic [7:0] e = dirM;
    if (lockM)                  e[5] = 1'b0;
    if (irqEnable)              e[4] = 1'b0;
    if (eclk2xEn)               e[2] = 1'b1;
    if (apiClkEn & apiClkRoute) e[1] = 1'b1;
    if (eclkEn)                 e[0] = 1'b1;
    return e;
  endfunction

  function automatic logic [7:0] expOut();
    logic [7:0] e = dataM;
    if (eclk2xEn)               e[2] = eclk2x;
    if (apiClkEn & apiClkRoute) e[1] = apiClk;
    if (eclkEn)                 e[0] = eclk;
    return e;
  endfunction

  task automatic writeRegs(input logic [7:0] d, input logic [7:0] dir);
    wrData = d; wrDataStb = 1'b1; wrDirStb = 1'b0;
    step();
    wrData = dir; wrDataStb = 1'b0; wrDirStb = 1'b1;
    step();
    wrDirStb = 1'b0;
    dataM = d; dirM = dir;
  endtask

  // R2 R3 R5 R6 R7 R8 R9 sweep over directions and override inputs
  task automatic sweep(input int dirStep);
    for (int d = 0; d < 256; d += dirStep) begin
      writeRegs(8'(d) ^ 8'h5A, 8'(d));
      for (int o = 0; o < 256; o++) begin
        irqEnable   = o[0];
        eclk2xEn    = o[1];
        apiClkEn    = o[2];
        apiClkRoute = o[3];
        eclkEn      = o[4];
        eclk2x      = o[5];
        apiClk      = o[6];
        eclk        = o[7];
        padIn       = 8'(d * 7 + o);
        #1;
        begin
          logic [7:0] eo = expOe();
          chk("R2/R5-R9 padOe", padOe, eo);
          chk("R2/R6-R9 padOut", padOut, expOut());
          chk("R3 rdPort", rdPort, (eo & dataM) | (~eo & padIn));
        end
      end
    end
    irqEnable = 0; eclk2xEn = 0; apiClkEn = 0; apiClkRoute = 0; eclkEn = 0;
    eclk2x = 0; apiClk = 0; eclk = 0;
  endtask

  initial begin
    rstN = 1'b0; wrData = '0; wrDataStb = 0; wrDirStb = 0;
    xMaskBit = 1'b1; irqEnable = 0; eclk2xEn = 0; eclk2x = 0;
    apiClkEn = 0; apiClkRoute = 0; apiClk = 0; eclkEn = 0; eclk = 0;
    padIn = 8'hA5; dbgPin = 1'b1; dbgOeReq = 1'b1;
    dataM = '0; dirM = '0; lockM = 0;

    repeat (3) step();
    // R1 reset state, R11 debug pad quiet in reset
    chk("R1 padOe", padOe, 8'h00);
    chk("R1 padOut", padOut, 8'h00);
    chk("R1 rdPort", rdPort, 8'hA5);
    chk("R11 dbgPadOe in reset", {7'b0, dbgPadOe}, 8'h00);

    rstN = 1'b1;
    #1;
    chk("R11 dbgPadOe after reset", {7'b0, dbgPadOe}, 8'h01);
    dbgPin = 1'b0;
    step();
    step();
    chk("R10 modeBit held 1", {7'b0, modeBit}, 8'h01);

    // R12 simultaneous load of both registers
    wrData = 8'hC3; wrDataStb = 1; wrDirStb = 1;
    step();
    wrDataStb = 0; wrDirStb = 0; dataM = 8'hC3; dirM = 8'hC3;
    chk("R12 both loaded padOe", padOe, 8'hC3);
    chk("R12 both loaded padOut", padOut, 8'hC3);

    sweep(1);

    // R4 sticky lock on pin 5
    writeRegs(8'hFF, 8'hFF);
    chk("R4 pin5 driven before lock", padOe, 8'hFF);
    xMaskBit = 1'b0;
    #1;
    chk("R4 no lock before edge", padOe, 8'hFF);
    step();
    lockM = 1;
    chk("R4 locked after edge", padOe, 8'hDF);
    xMaskBit = 1'b1;
    repeat (3) step();
    chk("R4 lock survives mask set", padOe, 8'hDF);
    writeRegs(8'h0F, 8'hFF);
    chk("R4 lock survives dir write", padOe, 8'hDF);
    sweep(17);

    // second reset: lock cleared, mode recaptured as 0
    dbgPin = 1'b0;
    rstN = 1'b0;
    repeat (2) step();
    dataM = '0; dirM = '0; lockM = 0;
    chk("R1 second reset padOe", padOe, 8'h00);
    rstN = 1'b1;
    dbgPin = 1'b1;
    step();
    chk("R10 modeBit recaptured 0", {7'b0, modeBit}, 8'h00);
    writeRegs(8'h00, 8'hFF);
    chk("R4 lock cleared by reset", padOe, 8'hFF);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule